// File: doc/BRIEF.md
# UART Interrupt Status and Enable Controller

This block gathers the interrupt conditions of a UART and turns them into four level-sensitive interrupt lines. The FIFO and receive logic report conditions as one-cycle pulses on `src_event`. Each pulse latches a pending bit. Each pending bit then drives its interrupt line for as long as the matching enable bit is set. Software acknowledges a condition by writing a one to its pending bit. For driver bring-up, software can also raise any pending bit through a separate force register.

Software reaches the three registers through a plain strobe port, with byte addresses and 32-bit data. A write takes effect at the clock edge where `reg_wr` is sampled high. A read is captured at the edge where `reg_rd` is sampled high. Its data appears on `reg_rdata`, qualified by `reg_rvalid`, in the following cycle. The port has no back-pressure: every strobe completes in one cycle.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bit order is fixed. Bit 0 is TX watermark, bit 1 is RX watermark, bit 2 is TX empty and bit 3 is RX overflow. A pulse on `src_event[i]` sets pending bit i at that clock edge.
- R2: `irq[i]` is high exactly when pending bit i and enable bit i are both set. It follows any register change in the cycle after the edge.
- R3: A write to the pending register (byte offset 0x0) clears each pending bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R4: A write to the force register (offset 0x8) ORs data bits 3:0 into the pending register.
- R5: Reading the force register returns zero.
- R6: A write to the enable register (offset 0x4) replaces all four enable bits, and the interrupt lines reflect the new enables in the next cycle.
- R7: After reset, the pending and enable registers are zero, every `irq` line is low, and `reg_rvalid` is low.
- R8: When a source pulse and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: A read from an unmapped word (offset 0xC) returns zero. A write there changes no register.
- R10: `reg_rdata` holds the register value sampled at the read edge, with `reg_rvalid` high for one cycle after it. Pending and enable bits read back in bits 3:0 and upper bits read as zero. Upper write-data bits are ignored, and address bits 1:0 are ignored.
- R11: Pending bits persist after their source pulse ends, and only a clear write lowers them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (4) | Byte address; bits 1:0 ignored |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| src_event | input | NUM_SRC (4) | One-cycle condition pulses from FIFO and receive logic |
| irq | output | NUM_SRC (4) | Level interrupt lines, one per source |

## Verification
The properties assume that every strobe and every `src_event` bit is a known 0 or 1 after reset. They also assume that reads and writes are never issued in the same cycle. The pending-clear property further assumes that no source pulse overlaps the clearing write, and the race case is covered by a property of its own. The bench changes every input only on falling clock edges and issues exactly one register operation per task. It raises source pulses either alone or deliberately aligned with a clear write, so that every check stays inside these assumptions.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // Source positions; the bit index is part of the software contract.
  typedef enum int unsigned {
    SRC_TX_WMARK = 0,
    SRC_RX_WMARK = 1,
    SRC_TX_DONE  = 2,
    SRC_RX_OVFL  = 3
  } irq_src_e;

  localparam int unsigned IRQ_SRC_COUNT = 4;

  // Byte offsets of the register words.
  localparam logic [7:0] OFF_PENDING = 8'h00;
  localparam logic [7:0] OFF_ENABLE  = 8'h04;
  localparam logic [7:0] OFF_FORCE   = 8'h08;

  // One-hot register selects produced by the address decoder.
  typedef struct packed {
    logic wr_pending;
    logic wr_enable;
    logic wr_force;
    logic rd_pending;
    logic rd_enable;
    logic rd_any;
  } reg_sel_t;
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output reg_sel_t          sel
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_PENDING = WORD_W'(OFF_PENDING >> 2);
  localparam logic [WORD_W-1:0] W_ENABLE  = WORD_W'(OFF_ENABLE  >> 2);
  localparam logic [WORD_W-1:0] W_FORCE   = WORD_W'(OFF_FORCE   >> 2);

  logic [WORD_W-1:0] word;
  logic hit_pending, hit_enable, hit_force;
  logic unused_byte_lanes;

  assign word              = addr[ADDR_W-1:2];
  assign unused_byte_lanes = ^addr[1:0];

  assign hit_pending = (word == W_PENDING);
  assign hit_enable  = (word == W_ENABLE);
  assign hit_force   = (word == W_FORCE);

  always_comb begin
    sel            = '0;
    sel.wr_pending = wr & hit_pending;
    sel.wr_enable  = wr & hit_enable;
    sel.wr_force   = wr & hit_force;
    sel.rd_pending = rd & hit_pending;
    sel.rd_enable  = rd & hit_enable;
    // Force and unmapped words read as zero; only the strobe matters.
    sel.rd_any     = rd;
  end
endmodule

// File: rtl/uart_irq_cell.sv
module uart_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic en_we,
  input  logic en_d,
  output logic pend_q,
  output logic en_q,
  output logic irq
);
  // Set sources take priority over an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (hw_set || sw_set) begin
      pend_q <= 1'b1;
    end else if (sw_clr) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  assign irq = pend_q & en_q;
endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
  import uart_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  reg_sel_t           sel,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] enable,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (sel.rd_pending) begin
      rd_next[NUM_SRC-1:0] = pend;
    end else if (sel.rd_enable) begin
      rd_next[NUM_SRC-1:0] = enable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= sel.rd_any;
      if (sel.rd_any) begin
        rdata <= rd_next;
      end
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int NUM_SRC = IRQ_SRC_COUNT,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  input  logic [NUM_SRC-1:0] src_event,
  output logic [NUM_SRC-1:0] irq
);
  reg_sel_t           sel;
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

  uart_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (reg_addr),
    .wr   (reg_wr),
    .rd   (reg_rd),
    .sel  (sel)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    uart_irq_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (src_event[i]),
      .sw_set (sel.wr_force & reg_wdata[i]),
      .sw_clr (sel.wr_pending & reg_wdata[i]),
      .en_we  (sel.wr_enable),
      .en_d   (reg_wdata[i]),
      .pend_q (pend_vec[i]),
      .en_q   (en_vec[i]),
      .irq    (irq[i])
    );
  end

  uart_irq_rdmux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rdmux (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .pend   (pend_vec),
    .enable (en_vec),
    .rdata  (reg_rdata),
    .rvalid (reg_rvalid)
  );
endmodule

// File: rtl/uart_irq_ctrl_sva.sv
module uart_irq_ctrl_sva #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               reg_rvalid,
  input logic [NUM_SRC-1:0] src_event,
  input logic [NUM_SRC-1:0] irq,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [NUM_SRC-1:0] en_vec
);
  localparam int WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;
  assign word = reg_addr[ADDR_W-1:2];

  assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend_vec == '0 && en_vec == '0 && irq == '0 && !reg_rvalid));

  assert_event_latches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_event != '0) |=> ((pend_vec & $past(src_event)) == $past(src_event)));

  assert_irq_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~en_vec) == '0) && ((irq & ~pend_vec) == '0));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && word == 0 && src_event == '0)
      |=> ((pend_vec & $past(reg_wdata[NUM_SRC-1:0])) == '0));

  assert_force_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && word == 2)
      |=> ((pend_vec & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0])));

  assert_force_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && word == 2) |=> (reg_rdata == '0));

  assert_enable_replace_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && word == 1) |=> (en_vec == $past(reg_wdata[NUM_SRC-1:0])));

  assert_set_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && word == 0 && (src_event & reg_wdata[NUM_SRC-1:0]) != '0)
      |=> ((pend_vec & $past(src_event)) == $past(src_event)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && word == 3) |=> (reg_rdata == '0));

  assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  assert_pending_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && word == 0) |=> (($past(pend_vec) & ~pend_vec) == '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_sva #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .src_event  (src_event),
  .irq        (irq),
  .pend_vec   (pend_vec),
  .en_vec     (en_vec)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [3:0]  src_event = '0;
  logic [3:0]  irq;

  int checks = 0;
  int fails = 0;
  logic [3:0] m_pend = '0;
  logic [3:0] m_en = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  uart_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .src_event(src_event), .irq(irq)
  );

  function automatic logic [31:0] model_read(logic [3:0] a);
    case (a[3:2])
      2'd0:    return {28'd0, m_pend};
      2'd1:    return {28'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  // Monitor: pops one expected item per read response.
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected rvalid got %h exp none", reg_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s rdata got %h exp %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic do_read(input logic [3:0] a, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_op(input logic wr, input logic [3:0] a, input logic [31:0] d,
                       input logic [3:0] ev);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; src_event = ev;
    @(negedge clk);
    reg_wr = 1'b0; src_event = '0;
    if (wr && a[3:2] == 2'd0) m_pend = m_pend & ~d[3:0];
    if (wr && a[3:2] == 2'd2) m_pend = m_pend | d[3:0];
    if (wr && a[3:2] == 2'd1) m_en = d[3:0];
    m_pend = m_pend | ev;
  endtask

  task automatic check_irq(input string tag);
    checks++;
    if (irq !== (m_pend & m_en)) begin
      fails++;
      $display("FAIL %s irq got %b exp %b", tag, irq, m_pend & m_en);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got running exp done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (irq !== 4'b0 || reg_rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R7 in reset got irq %b rvalid %b exp 0 0", irq, reg_rvalid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_irq("R7");
    do_read(4'h0, "R7 pending");
    do_read(4'h4, "R7 enable");

    do_op(1'b1, 4'h4, 32'h0000_000F, 4'h0);
    do_read(4'h4, "R6 enable");
    check_irq("R6");

    do_op(1'b0, 4'h0, 32'h0, 4'b0001);          // TX watermark
    check_irq("R1 tx watermark");
    repeat (3) @(negedge clk);
    check_irq("R11 sticky");
    do_op(1'b0, 4'h0, 32'h0, 4'b1000);          // RX overflow
    check_irq("R1 rx overflow");
    do_read(4'h0, "R1 pending");

    do_op(1'b1, 4'h4, 32'h0000_000E, 4'h0);
    check_irq("R6 disable bit0");
    do_read(4'h0, "R2 pending kept");

    do_op(1'b1, 4'h0, 32'h0000_0001, 4'h0);
    check_irq("R3 clear bit0");
    do_read(4'h0, "R3 pending");
    do_op(1'b1, 4'h0, 32'h0000_0008, 4'h0);
    check_irq("R3 clear bit3");

    do_op(1'b1, 4'h8, 32'h0000_0006, 4'h0);
    check_irq("R4 force");
    do_read(4'h0, "R4 pending");
    do_read(4'h8, "R5 force readback");

    do_op(1'b1, 4'h8, 32'hFFFF_FFF0, 4'h0);
    do_read(4'h0, "R10 upper data ignored");

    do_op(1'b1, 4'h0, 32'h0000_0006, 4'b0010);  // race on bit1
    check_irq("R8 set beats clear");
    do_read(4'h0, "R8 pending");

    do_read(4'hC, "R9 unmapped read");
    do_op(1'b1, 4'hC, 32'h0000_000F, 4'h0);
    do_read(4'h0, "R9 pending after unmapped write");
    do_read(4'h4, "R9 enable after unmapped write");
    check_irq("R9");

    do_read(4'h5, "R10 low address bits");

    do_op(1'b1, 4'h4, 32'h0, 4'h0);
    do_op(1'b0, 4'h0, 32'h0, 4'b0100);
    check_irq("R2 masked");
    do_op(1'b1, 4'h4, 32'h0000_0004, 4'h0);
    check_irq("R2 unmasked");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing responses got %0d exp 0", exp_q.size());
    end
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule